// File: doc/BRIEF.md
# Single-Entry Post-Translation Store Buffer

This block holds one committed store after address translation, beside the data cache, so the pipeline can retire a qualifying store without waiting for memory. The held store is written out later through a memory port that it shares with the instruction prefetcher. An external arbiter decides which side owns that port. The entry is retired only in a cycle where its own request is raised, the arbiter has granted the store side, and memory signals ready. A ready pulse that belongs to a prefetch grant leaves the entry in place.

Only a narrow class of stores enters the buffer: translated, user-mode, naturally aligned 32-bit words. Every other store is flagged for the direct path and is held back while an entry is still pending, which keeps stores in program order. The buffered data never updates the cache. When the entry drains, the block invalidates the cache line that holds its address. Privilege changes, writes to the translation base, translation fences and, in the conservative setting, the next instruction fetch must all wait until the entry is empty. A load to the buffered word either receives the buffered data or stalls, depending on a build parameter. Seven saturating counters record the events.

Top module: `post_xlat_store_buf`

## Requirements
- R1: After reset the entry is empty, mem_req_o is low and all seven counters read zero.
- R2: A store with st_xlat_i=1, st_priv_i=2'b00 (user), st_size_i=2'b10 (word) and st_paddr_i[1:0]=0 is accepted when the entry is empty. From the next cycle, mem_req_o is high and mem_addr_o and mem_data_o carry that store.
- R3: Any other store raises st_bypass_o in its own cycle and does not enter the buffer. While the entry is valid, such a store also raises st_stall_o.
- R4: The entry is cleared only in a cycle with mem_req_o, mem_gnt_store_i and mem_ready_i all high. When mem_ready_i is high and mem_gnt_store_i is low (prefetch owns the port), the entry stays valid.
- R5: In the retiring cycle, dc_inv_o is high and dc_inv_addr_o is the entry address with its low log2(LINE_BYTES) bits cleared (bits [5:0] with the default of 64). At all other times dc_inv_o is low.
- R6: A qualifying store that arrives while the entry is valid and not retiring raises st_stall_o. In the retiring cycle the new store is accepted, so the entry stays valid with the new contents.
- R7: A load whose address bits [PA_W-1:2] match the valid entry behaves according to FWD_LOAD. With FWD_LOAD=1 it gets ld_fwd_o=1 and ld_data_o set to the entry data. With FWD_LOAD=0 it gets ld_stall_o=1. A load to any other word is neither stalled nor forwarded.
- R8: Each drain request (drain_priv_i, drain_xbase_i, drain_xfence_i) raises drain_busy_o while the entry is valid. When the entry is empty, drain_busy_o is low in the same cycle.
- R9: With FETCH_DRAIN=1, fetch_req_i raises fetch_stall_o while the entry is valid, and fetch_stall_o is low while the entry is empty.
- R10: Counter slots in cnt_o, each CNT_W bits wide at slot index i*CNT_W, count once per cycle of their event: 0 stores accepted, 1 stores retired, 2 loads forwarded, 3 cycles with the entry valid, 4 cycles a qualifying store stalled on a full entry, 5 cycles a load or direct-path store waited for ordering, 6 cycles drain_busy_o or fetch_stall_o was high. A counter's new value is visible one cycle after its event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Committed store present |
| st_paddr_i | input | PA_W | Physical store address |
| st_data_i | input | 32 | Store data |
| st_priv_i | input | 2 | Privilege of the store: 00 user, 01 supervisor, 11 machine |
| st_xlat_i | input | 1 | Address came through translation |
| st_size_i | input | 2 | Access size: 00 byte, 01 half, 10 word |
| st_stall_o | output | 1 | Store must be held by the pipeline |
| st_bypass_o | output | 1 | Store is not buffered and takes the direct path |
| ld_valid_i | input | 1 | Load lookup |
| ld_paddr_i | input | PA_W | Physical load address |
| ld_fwd_o | output | 1 | Load is served from the entry |
| ld_data_o | output | 32 | Forwarded data |
| ld_stall_o | output | 1 | Load must wait for the entry to drain |
| drain_priv_i | input | 1 | Privilege change pending |
| drain_xbase_i | input | 1 | Translation base write pending |
| drain_xfence_i | input | 1 | Translation fence pending |
| fetch_req_i | input | 1 | Next instruction fetch wants to proceed |
| drain_busy_o | output | 1 | Drain request still waiting on the entry |
| fetch_stall_o | output | 1 | Fetch held until the entry drains |
| mem_req_o | output | 1 | Store-side memory request |
| mem_addr_o | output | PA_W | Store address to memory |
| mem_data_o | output | 32 | Store data to memory |
| mem_gnt_store_i | input | 1 | Arbiter grant is on the store side |
| mem_ready_i | input | 1 | Memory completes the granted access |
| dc_inv_o | output | 1 | Invalidate a data cache line |
| dc_inv_addr_o | output | PA_W | Line address to invalidate |
| cnt_o | output | 7*CNT_W | Event counters, slot i at [i*CNT_W +: CNT_W] |

## Verification
Stores are presented with each single disqualifier in turn (supervisor, machine, untranslated, half size, misaligned), alongside a fully qualifying store. This separates the acceptance filter from the direct-path flag. Drain is tried under three port conditions: ready with the grant on the prefetch side, grant without ready, and grant with ready. Only the last may retire the entry, which exposes a retire that keys on ready alone. A second store arriving behind a pending one, first while memory withholds, then in the retiring cycle, distinguishes a stall from a lost or overwritten entry. Loads to the buffered word and to a neighbouring word, and each drain source with the entry full and empty, show that the ordering outputs depend on both the address and the occupancy.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_M = 2'b11
  } priv_e;

  typedef enum logic [1:0] {
    SZ_B = 2'b00,
    SZ_H = 2'b01,
    SZ_W = 2'b10
  } size_e;

  localparam int unsigned CNT_ACC   = 0;
  localparam int unsigned CNT_DRN   = 1;
  localparam int unsigned CNT_FWD   = 2;
  localparam int unsigned CNT_VAL   = 3;
  localparam int unsigned CNT_FULL  = 4;
  localparam int unsigned CNT_ORD   = 5;
  localparam int unsigned CNT_DSTL  = 6;
  localparam int unsigned NUM_CNT   = 7;
endpackage

// File: rtl/sb_filter.sv
module sb_filter
  import sb_pkg::*;
#(
  parameter int unsigned PA_W = 34
) (
  input  logic            valid_i,
  input  logic [PA_W-1:0] paddr_i,
  input  logic [1:0]      priv_i,
  input  logic            xlat_i,
  input  logic [1:0]      size_i,
  output logic            qual_o,
  output logic            bypass_o
);
  logic user_ok, size_ok, align_ok;

  always_comb begin
    user_ok  = (priv_e'(priv_i) == PRIV_U);
    size_ok  = (size_e'(size_i) == SZ_W);
    align_ok = (paddr_i[1:0] == 2'b00);
    qual_o   = valid_i && xlat_i && user_ok && size_ok && align_ok;
    bypass_o = valid_i && !qual_o;
  end
endmodule

// File: rtl/sb_entry.sv
module sb_entry #(
  parameter int unsigned PA_W = 34,
  parameter int unsigned DW   = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic [PA_W-1:0] push_addr_i,
  input  logic [DW-1:0]   push_data_i,
  input  logic            gnt_i,
  input  logic            rdy_i,
  output logic            valid_o,
  output logic [PA_W-1:0] addr_o,
  output logic [DW-1:0]   data_o,
  output logic            retire_o
);
  logic            valid_q;
  logic [PA_W-1:0] addr_q;
  logic [DW-1:0]   data_q;

  // request is implied by valid; retire needs our own grant
  assign retire_o = valid_q && gnt_i && rdy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (push_i) begin
      valid_q <= 1'b1;
      addr_q  <= push_addr_i;
      data_q  <= push_data_i;
    end else if (retire_o) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!valid_q || (gnt_i && rdy_i)));

  assert_keep_on_prefetch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !(gnt_i && rdy_i)) |=> valid_o);

  assert_hold_contents_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !gnt_i) |=> ($stable(addr_o) && $stable(data_o)));
endmodule

// File: rtl/sb_order.sv
module sb_order #(
  parameter int unsigned PA_W        = 34,
  parameter bit          FWD_LOAD    = 1'b0,
  parameter bit          FETCH_DRAIN = 1'b1
) (
  input  logic            st_valid_i,
  input  logic            qual_i,
  input  logic            ent_valid_i,
  input  logic            retire_i,
  input  logic [PA_W-1:0] ent_addr_i,
  input  logic            ld_valid_i,
  input  logic [PA_W-1:0] ld_paddr_i,
  input  logic            drain_any_i,
  input  logic            fetch_req_i,
  output logic            accept_o,
  output logic            st_stall_o,
  output logic            full_wait_o,
  output logic            order_wait_o,
  output logic            fwd_o,
  output logic            ld_stall_o,
  output logic            drain_busy_o,
  output logic            fetch_stall_o
);
  logic ld_hit, bypass_wait;

  always_comb begin
    ld_hit        = ld_valid_i && ent_valid_i && (ld_paddr_i[PA_W-1:2] == ent_addr_i[PA_W-1:2]);
    accept_o      = qual_i && (!ent_valid_i || retire_i);
    full_wait_o   = qual_i && ent_valid_i && !retire_i;
    // direct-path store must not overtake the pending entry
    bypass_wait   = st_valid_i && !qual_i && ent_valid_i;
    st_stall_o    = full_wait_o || bypass_wait;
    drain_busy_o  = drain_any_i && ent_valid_i;
  end

  generate
    if (FWD_LOAD) begin : g_fwd
      assign fwd_o      = ld_hit;
      assign ld_stall_o = 1'b0;
    end else begin : g_stall
      assign fwd_o      = 1'b0;
      assign ld_stall_o = ld_hit;
    end
    if (FETCH_DRAIN) begin : g_fetch_gate
      assign fetch_stall_o = fetch_req_i && ent_valid_i;
    end else begin : g_fetch_free
      assign fetch_stall_o = 1'b0;
    end
  endgenerate

  assign order_wait_o = ld_stall_o || bypass_wait;
endmodule

// File: rtl/sb_counters.sv
module sb_counters #(
  parameter int unsigned N = 7,
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] ev_i,
  output logic [N*W-1:0] cnt_o
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  for (genvar i = 0; i < N; i++) begin : g_cnt
    logic [W-1:0] c_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      c_q <= '0;
      else if (ev_i[i] && c_q != MAXV)  c_q <= c_q + 1'b1;
    end
    assign cnt_o[i*W +: W] = c_q;
  end
endmodule

// File: rtl/post_xlat_store_buf.sv
module post_xlat_store_buf
  import sb_pkg::*;
#(
  parameter int unsigned PA_W        = 34,
  parameter int unsigned LINE_BYTES  = 64,
  parameter int unsigned CNT_W       = 16,
  parameter bit          FWD_LOAD    = 1'b0,
  parameter bit          FETCH_DRAIN = 1'b1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   st_valid_i,
  input  logic [PA_W-1:0]        st_paddr_i,
  input  logic [31:0]            st_data_i,
  input  logic [1:0]             st_priv_i,
  input  logic                   st_xlat_i,
  input  logic [1:0]             st_size_i,
  output logic                   st_stall_o,
  output logic                   st_bypass_o,
  input  logic                   ld_valid_i,
  input  logic [PA_W-1:0]        ld_paddr_i,
  output logic                   ld_fwd_o,
  output logic [31:0]            ld_data_o,
  output logic                   ld_stall_o,
  input  logic                   drain_priv_i,
  input  logic                   drain_xbase_i,
  input  logic                   drain_xfence_i,
  input  logic                   fetch_req_i,
  output logic                   drain_busy_o,
  output logic                   fetch_stall_o,
  output logic                   mem_req_o,
  output logic [PA_W-1:0]        mem_addr_o,
  output logic [31:0]            mem_data_o,
  input  logic                   mem_gnt_store_i,
  input  logic                   mem_ready_i,
  output logic                   dc_inv_o,
  output logic [PA_W-1:0]        dc_inv_addr_o,
  output logic [NUM_CNT*CNT_W-1:0] cnt_o
);
  localparam int unsigned OFF_W = $clog2(LINE_BYTES);

  logic            qual, accept, retire, ent_valid;
  logic            full_wait, order_wait, fwd;
  logic [PA_W-1:0] ent_addr;
  logic [31:0]     ent_data;
  logic [NUM_CNT-1:0] ev;

  sb_filter #(.PA_W(PA_W)) u_filter (
    .valid_i (st_valid_i),
    .paddr_i (st_paddr_i),
    .priv_i  (st_priv_i),
    .xlat_i  (st_xlat_i),
    .size_i  (st_size_i),
    .qual_o  (qual),
    .bypass_o(st_bypass_o)
  );

  sb_entry #(.PA_W(PA_W), .DW(32)) u_entry (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (accept),
    .push_addr_i(st_paddr_i),
    .push_data_i(st_data_i),
    .gnt_i      (mem_gnt_store_i),
    .rdy_i      (mem_ready_i),
    .valid_o    (ent_valid),
    .addr_o     (ent_addr),
    .data_o     (ent_data),
    .retire_o   (retire)
  );

  sb_order #(.PA_W(PA_W), .FWD_LOAD(FWD_LOAD), .FETCH_DRAIN(FETCH_DRAIN)) u_order (
    .st_valid_i   (st_valid_i),
    .qual_i       (qual),
    .ent_valid_i  (ent_valid),
    .retire_i     (retire),
    .ent_addr_i   (ent_addr),
    .ld_valid_i   (ld_valid_i),
    .ld_paddr_i   (ld_paddr_i),
    .drain_any_i  (drain_priv_i || drain_xbase_i || drain_xfence_i),
    .fetch_req_i  (fetch_req_i),
    .accept_o     (accept),
    .st_stall_o   (st_stall_o),
    .full_wait_o  (full_wait),
    .order_wait_o (order_wait),
    .fwd_o        (fwd),
    .ld_stall_o   (ld_stall_o),
    .drain_busy_o (drain_busy_o),
    .fetch_stall_o(fetch_stall_o)
  );

  assign mem_req_o     = ent_valid;
  assign mem_addr_o    = ent_addr;
  assign mem_data_o    = ent_data;
  assign dc_inv_o      = retire;
  assign dc_inv_addr_o = {ent_addr[PA_W-1:OFF_W], {OFF_W{1'b0}}};
  assign ld_fwd_o      = fwd;
  assign ld_data_o     = ent_data;

  always_comb begin
    ev           = '0;
    ev[CNT_ACC]  = accept;
    ev[CNT_DRN]  = retire;
    ev[CNT_FWD]  = fwd;
    ev[CNT_VAL]  = ent_valid;
    ev[CNT_FULL] = full_wait;
    ev[CNT_ORD]  = order_wait;
    ev[CNT_DSTL] = drain_busy_o || fetch_stall_o;
  end

  sb_counters #(.N(NUM_CNT), .W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ev_i  (ev),
    .cnt_o (cnt_o)
  );

  assert_accept_filter_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_i && !st_stall_o && !st_bypass_o) |=>
      (mem_req_o && mem_addr_o[1:0] == 2'b00));

  assert_inv_needs_grant_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dc_inv_o |-> (mem_req_o && mem_gnt_store_i && mem_ready_i));

  assert_drain_busy_pending_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_busy_o |-> mem_req_o);

  assert_fetch_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_stall_o |-> (fetch_req_i && mem_req_o));

  assert_bypass_not_buffered_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_bypass_o && !mem_req_o) |=> !mem_req_o);

  assert_load_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ld_fwd_o && ld_stall_o));
endmodule

// File: tb/tb_post_xlat_store_buf.sv
module tb_post_xlat_store_buf;
  localparam int PA_W = 34;
  localparam int CW   = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic            st_valid, st_xlat, ld_valid;
  logic [PA_W-1:0] st_paddr, ld_paddr;
  logic [31:0]     st_data;
  logic [1:0]      st_priv, st_size;
  logic            drn_priv, drn_xbase, drn_xfence, fetch_req, gnt, rdy;

  logic            st_stall, st_bypass, ld_fwd, ld_stall, drain_busy, fetch_stall;
  logic            mem_req, dc_inv;
  logic [31:0]     ld_data, mem_data;
  logic [PA_W-1:0] mem_addr, inv_addr;
  logic [7*CW-1:0] cnt;

  logic            f_st_stall, f_st_bypass, f_ld_fwd, f_ld_stall, f_drain_busy, f_fetch_stall;
  logic            f_mem_req, f_dc_inv;
  logic [31:0]     f_ld_data, f_mem_data;
  logic [PA_W-1:0] f_mem_addr, f_inv_addr;
  logic [7*CW-1:0] f_cnt;

  post_xlat_store_buf #(.FWD_LOAD(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .st_valid_i(st_valid), .st_paddr_i(st_paddr), .st_data_i(st_data),
    .st_priv_i(st_priv), .st_xlat_i(st_xlat), .st_size_i(st_size),
    .st_stall_o(st_stall), .st_bypass_o(st_bypass),
    .ld_valid_i(ld_valid), .ld_paddr_i(ld_paddr),
    .ld_fwd_o(ld_fwd), .ld_data_o(ld_data), .ld_stall_o(ld_stall),
    .drain_priv_i(drn_priv), .drain_xbase_i(drn_xbase), .drain_xfence_i(drn_xfence),
    .fetch_req_i(fetch_req), .drain_busy_o(drain_busy), .fetch_stall_o(fetch_stall),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_data_o(mem_data),
    .mem_gnt_store_i(gnt), .mem_ready_i(rdy),
    .dc_inv_o(dc_inv), .dc_inv_addr_o(inv_addr), .cnt_o(cnt)
  );

  post_xlat_store_buf #(.FWD_LOAD(1'b1)) dut_fwd (
    .clk_i(clk), .rst_ni(rst_ni),
    .st_valid_i(st_valid), .st_paddr_i(st_paddr), .st_data_i(st_data),
    .st_priv_i(st_priv), .st_xlat_i(st_xlat), .st_size_i(st_size),
    .st_stall_o(f_st_stall), .st_bypass_o(f_st_bypass),
    .ld_valid_i(ld_valid), .ld_paddr_i(ld_paddr),
    .ld_fwd_o(f_ld_fwd), .ld_data_o(f_ld_data), .ld_stall_o(f_ld_stall),
    .drain_priv_i(drn_priv), .drain_xbase_i(drn_xbase), .drain_xfence_i(drn_xfence),
    .fetch_req_i(fetch_req), .drain_busy_o(f_drain_busy), .fetch_stall_o(f_fetch_stall),
    .mem_req_o(f_mem_req), .mem_addr_o(f_mem_addr), .mem_data_o(f_mem_data),
    .mem_gnt_store_i(gnt), .mem_ready_i(rdy),
    .dc_inv_o(f_dc_inv), .dc_inv_addr_o(f_inv_addr), .cnt_o(f_cnt)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference state
  bit              m_v;
  logic [PA_W-1:0] m_addr;
  logic [31:0]     m_data;
  int              mc[7];

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic idle();
    st_valid = 0; st_paddr = '0; st_data = '0; st_priv = 2'b00; st_xlat = 0; st_size = 2'b10;
    ld_valid = 0; ld_paddr = '0;
    drn_priv = 0; drn_xbase = 0; drn_xfence = 0; fetch_req = 0; gnt = 0; rdy = 0;
  endtask

  task automatic put_st(input logic [PA_W-1:0] a, input logic [31:0] d,
                        input logic [1:0] p, input logic x, input logic [1:0] s);
    st_valid = 1; st_paddr = a; st_data = d; st_priv = p; st_xlat = x; st_size = s;
  endtask

  // called just after a falling edge with inputs set
  task automatic tick();
    bit q, ret, hit, acc, full, ordst, busy, fst;
    #1;
    q     = st_valid && st_xlat && st_priv == 2'b00 && st_size == 2'b10 && st_paddr[1:0] == 2'b00;
    ret   = m_v && gnt && rdy;
    hit   = m_v && ld_valid && (ld_paddr[PA_W-1:2] == m_addr[PA_W-1:2]);
    acc   = q && (!m_v || ret);
    full  = q && m_v && !ret;
    ordst = st_valid && !q && m_v;
    busy  = (drn_priv || drn_xbase || drn_xfence) && m_v;
    fst   = fetch_req && m_v;

    chk("R4", "mem_req", mem_req, m_v);
    if (m_v) begin
      chk("R2", "mem_addr", mem_addr, m_addr);
      chk("R2", "mem_data", mem_data, m_data);
    end
    chk("R3", "bypass", st_bypass, st_valid && !q);
    chk("R6", "st_stall", st_stall, full || ordst);
    chk("R5", "dc_inv", dc_inv, ret);
    if (ret) chk("R5", "inv_addr", inv_addr, {m_addr[PA_W-1:6], 6'b0});
    chk("R7", "ld_stall", ld_stall, hit);
    chk("R7", "ld_fwd(stall cfg)", ld_fwd, 0);
    chk("R7", "fwd cfg ld_fwd", f_ld_fwd, hit);
    chk("R7", "fwd cfg ld_stall", f_ld_stall, 0);
    if (hit) chk("R7", "fwd data", f_ld_data, m_data);
    chk("R8", "drain_busy", drain_busy, busy);
    chk("R9", "fetch_stall", fetch_stall, fst);
    for (int i = 0; i < 7; i++) chk("R10", $sformatf("cnt[%0d]", i), cnt[i*CW +: CW], mc[i]);

    @(posedge clk);
    if (acc)   mc[0]++;
    if (ret)   mc[1]++;
    if (m_v)   mc[3]++;
    if (full)  mc[4]++;
    if (hit || ordst) mc[5]++;
    if (busy || fst)  mc[6]++;
    if (acc) begin
      m_v = 1; m_addr = st_paddr; m_data = st_data;
    end else if (ret) begin
      m_v = 0;
    end
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle();
    m_v = 0; m_addr = '0; m_data = '0;
    for (int i = 0; i < 7; i++) mc[i] = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;

    // R1 reset state
    chk("R1", "mem_req after reset", mem_req, 0);
    chk("R1", "counters after reset", cnt, 0);
    tick();

    // R2 accept, R4 prefetch owns port with ready high
    put_st(34'h0_1000_0040, 32'hA5A5_0001, 2'b00, 1, 2'b10);
    tick(); idle();
    gnt = 0; rdy = 1; tick(); tick();          // R4 prefetch wins, entry survives
    chk("R4", "entry after prefetch ready", mem_req, 1);
    gnt = 1; rdy = 0; tick();                  // grant without ready
    gnt = 1; rdy = 1; tick();                  // R5 retire + invalidate
    idle(); tick();
    chk("R4", "empty after retire", mem_req, 0);

    // R3 disqualified stores with empty entry
    put_st(34'h0_2000_0000, 32'h1, 2'b01, 1, 2'b10); tick();
    put_st(34'h0_2000_0000, 32'h2, 2'b11, 1, 2'b10); tick();
    put_st(34'h0_2000_0000, 32'h3, 2'b00, 0, 2'b10); tick();
    put_st(34'h0_2000_0000, 32'h4, 2'b00, 1, 2'b01); tick();
    put_st(34'h0_2000_0002, 32'h5, 2'b00, 1, 2'b10); tick();
    idle(); tick();
    chk("R3", "nothing buffered", mem_req, 0);

    // R8/R9 with empty entry
    drn_priv = 1; drn_xbase = 1; drn_xfence = 1; fetch_req = 1; tick(); idle();

    // R6 full entry then same-cycle replace
    put_st(34'h0_3000_0104, 32'hB0B0_0002, 2'b00, 1, 2'b10); tick();
    put_st(34'h0_3000_0208, 32'hC0C0_0003, 2'b00, 1, 2'b10);
    tick(); gnt = 0; rdy = 1; tick();          // stalled, prefetch owns port
    gnt = 1; rdy = 1; tick();                  // old retires, new accepted
    idle(); tick();
    chk("R6", "replacement data held", mem_data, 32'hC0C0_0003);

    // R7 loads
    ld_valid = 1; ld_paddr = 34'h0_3000_020A; tick();   // same word
    ld_paddr = 34'h0_3000_020C; tick();                 // next word
    idle();
    // R3 direct-path store behind entry
    put_st(34'h0_3000_0300, 32'h9, 2'b11, 0, 2'b10); tick(); idle();
    // R8 each drain source, R9 fetch
    drn_priv = 1;   tick(); idle();
    drn_xbase = 1;  tick(); idle();
    drn_xfence = 1; tick(); idle();
    fetch_req = 1;  tick();
    fetch_req = 1; gnt = 1; rdy = 1; tick();
    idle(); fetch_req = 1; drn_priv = 1; tick();
    idle(); tick(); tick();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule